// File: doc/BRIEF.md
# Program/Erase Completion Polling Unit

This block follows an internally timed program or erase operation of a nonvolatile byte array and changes what host reads return while that operation is in progress. A host can therefore find out when the operation is over just by reading the array, with no clock of its own and no separate status register. The array cell physics are not modelled. A down-counter stands in for the program and erase durations, and each of the three operation kinds has its own duration parameter, so short runs are possible in simulation.

A start request carries the operation kind, the address and data of the byte just written, and the three bus strobes (chip select, output enable, write strobe, all active low). The request is taken only when those strobes form a legal write. While busy, the read path reports status instead of stored data. The top bit of a read is the inverse of the written top bit when a program is polled at its own address, and it reads 0 during an erase. The next bit down changes value on every read. The remaining bits pass through from the array. When the operation ends, the status bit stops changing and reads return the true array data. An active-low reset aborts the operation at once.

Top module: `pollUnit`

## Requirements
- R1: A start request is accepted only when it comes while idle with ceN=0, oeN=1, weN=0 and opType in {0 = byte program, 1 = sector erase, 2 = chip erase}. busy goes high at the clock edge that samples the accepted request. Any other strobe combination, or opType 3, leaves busy low.
- R2: After acceptance, busy stays high for exactly PROG_CYC, SECT_CYC or CHIP_CYC clock cycles for opType 0, 1 or 2 respectively, and then falls.
- R3: A start request made while busy is ignored. The running operation keeps its original duration.
- R4: While a byte program is busy, a read whose rdAddr equals the captured progAddr returns bit 7 equal to the inverse of progData bit 7. A read at any other address returns arrayData bit 7 on bit 7.
- R5: While a sector or chip erase is busy, bit 7 of every read is 0. This is the inverse of the erased value 1.
- R6: While busy, bit 6 of rdData is a toggle bit. It is 0 for the first read after each accepted start, and every clock cycle with rdEn=1 while busy inverts it for the next read. Cycles with rdEn=0 leave it unchanged, so polling may start at any point in the busy period.
- R7: While busy, rdData bits 5 to 0 equal arrayData bits 5 to 0.
- R8: While idle, rdData equals arrayData on all bits. After completion, bit 6 no longer changes between reads.
- R9: Driving rstN low clears busy immediately, without waiting for a clock edge, and aborts the operation. After release, reads return arrayData, and the next operation starts with the toggle bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; aborts the operation |
| startReq | input | 1 | Request to start an operation |
| opType | input | 2 | 0 byte program, 1 sector erase, 2 chip erase, 3 invalid |
| progAddr | input | ADDR_W | Address of the programmed byte |
| progData | input | DATA_W | Data written by the program |
| ceN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write strobe, active low |
| rdEn | input | 1 | A host read happens this cycle |
| rdAddr | input | ADDR_W | Address of the host read |
| arrayData | input | DATA_W | Stored array contents at rdAddr |
| busy | output | 1 | Operation in progress |
| rdData | output | DATA_W | Data returned to the host read |

## Verification
Every clock cycle, the assertions check the idle pass-through, the pass-through of the low bits while busy, the erase and program values of bit 7, the inversion of bit 6 after each read, the gating of busy by a legal start, and the busy length for each operation kind. Only the bench scenarios can show the full sweep of strobe and opcode combinations. They also cover the ignored restart, the toggle value restarting at 0 after a start or an abort, the asynchronous clearing by reset, and reads that begin late in the busy period.

// File: rtl/pollPkg.sv
package pollPkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_NONE = 2'd3
  } opKind_e;

  typedef struct packed {
    logic capture;
    logic flip;
  } pollStrobe_t;
endpackage

// File: rtl/pollCtrl.sv
module pollCtrl import pollPkg::*; #(
  parameter int PROG_CYC = 5,
  parameter int SECT_CYC = 9,
  parameter int CHIP_CYC = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic [1:0]  opType,
  input  logic        ceN,
  input  logic        oeN,
  input  logic        weN,
  input  logic        rdEn,
  output logic        busy,
  output pollStrobe_t strb
);
  localparam int MAX_A  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_C  = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] durSel;
  logic             writeGate;
  logic             accept;

  always_comb begin
    case (opKind_e'(opType))
      OP_PROG: durSel = CNT_W'(PROG_CYC);
      OP_SECT: durSel = CNT_W'(SECT_CYC);
      OP_CHIP: durSel = CNT_W'(CHIP_CYC);
      default: durSel = '0;
    endcase
  end

  assign writeGate = oeN && !ceN && !weN;
  assign accept    = startReq && !busy && writeGate && (opKind_e'(opType) != OP_NONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      cntQ <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cntQ <= durSel;
    end else if (busy) begin
      if (cntQ == CNT_W'(1)) busy <= 1'b0;
      cntQ <= cntQ - CNT_W'(1);
    end
  end

  assign strb.capture = accept;
  assign strb.flip    = busy && rdEn;
endmodule

// File: rtl/pollData.sv
module pollData import pollPkg::*; #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrobe_t       strb,
  input  logic              busy,
  input  logic [1:0]        opType,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [DATA_W-1:0] progData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic [ADDR_W-1:0] addrQ;
  logic              pollRefQ;
  opKind_e           opQ;
  logic              togQ;
  logic              pollBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      pollRefQ <= 1'b0;
      opQ      <= OP_NONE;
      togQ     <= 1'b0;
    end else if (strb.capture) begin
      addrQ    <= progAddr;
      pollRefQ <= progData[POLL_BIT];
      opQ      <= opKind_e'(opType);
      togQ     <= 1'b0;
    end else if (strb.flip) begin
      togQ     <= ~togQ;
    end
  end

  always_comb begin
    if (opQ == OP_PROG)
      pollBit = (rdAddr == addrQ) ? ~pollRefQ : arrayData[POLL_BIT];
    else
      pollBit = 1'b0;
    if (busy)
      rdData = {pollBit, togQ, arrayData[TOG_BIT-1:0]};
    else
      rdData = arrayData;
  end
endmodule

// File: rtl/pollUnit.sv
module pollUnit import pollPkg::*; #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 8,
  parameter int PROG_CYC = 5,
  parameter int SECT_CYC = 9,
  parameter int CHIP_CYC = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [1:0]        opType,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [DATA_W-1:0] progData,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrayData,
  output logic              busy,
  output logic [DATA_W-1:0] rdData
);
  pollStrobe_t strb;

  pollCtrl #(.PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opType(opType),
    .ceN(ceN), .oeN(oeN), .weN(weN), .rdEn(rdEn), .busy(busy), .strb(strb)
  );

  pollData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .opType(opType),
    .progAddr(progAddr), .progData(progData), .rdAddr(rdAddr),
    .arrayData(arrayData), .rdData(rdData)
  );
endmodule

// File: rtl/pollUnitChk.sv
module pollUnitChk #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 8,
  parameter int PROG_CYC = 5,
  parameter int SECT_CYC = 9,
  parameter int CHIP_CYC = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic [1:0]        opType,
  input logic [ADDR_W-1:0] progAddr,
  input logic [DATA_W-1:0] progData,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] arrayData,
  input logic              busy,
  input logic [DATA_W-1:0] rdData
);
  logic [31:0]       busyCnt;
  logic [31:0]       expDur;
  logic [1:0]        expOp;
  logic [ADDR_W-1:0] expAddr;
  logic              expTop;
  logic              legalStart;

  assign legalStart = startReq && !busy && oeN && !ceN && !weN && (opType != 2'd3);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
      expDur  <= '0;
      expOp   <= 2'd3;
      expAddr <= '0;
      expTop  <= 1'b0;
    end else begin
      busyCnt <= busy ? busyCnt + 32'd1 : 32'd0;
      if (legalStart) begin
        expDur  <= (opType == 2'd0) ? PROG_CYC : (opType == 2'd1) ? SECT_CYC : CHIP_CYC;
        expOp   <= opType;
        expAddr <= progAddr;
        expTop  <= progData[DATA_W-1];
      end
    end
  end

  assert_start_gated_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq && oeN && !ceN && !weN && (opType != 2'd3)));

  assert_duration_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyCnt == expDur);

  assert_prog_poll_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && expOp == 2'd0 && rdAddr == expAddr) |-> rdData[DATA_W-1] != expTop);

  assert_erase_poll_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && expOp != 2'd0) |-> !rdData[DATA_W-1]);

  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rdEn) ##1 busy |-> rdData[DATA_W-2] != $past(rdData[DATA_W-2]));

  assert_low_bits_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> rdData[DATA_W-3:0] == arrayData[DATA_W-3:0]);

  assert_idle_pass_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> rdData == arrayData);
endmodule

bind pollUnit pollUnitChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
) uChk (.*);

// File: tb/sim_pollUnit.sv
`timescale 1ns/1ps
module sim_pollUnit;
  localparam int ADDR_W = 18;
  localparam int DATA_W = 8;
  localparam int PROG_CYC = 5;
  localparam int SECT_CYC = 9;
  localparam int CHIP_CYC = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [1:0] opType = 2'd0;
  logic [ADDR_W-1:0] progAddr = '0;
  logic [DATA_W-1:0] progData = '0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic rdEn = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] arrayData = 8'h5A;
  logic busy;
  logic [DATA_W-1:0] rdData;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pollUnit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYC(PROG_CYC),
             .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opType(opType),
    .progAddr(progAddr), .progData(progData), .ceN(ceN), .oeN(oeN), .weN(weN),
    .rdEn(rdEn), .rdAddr(rdAddr), .arrayData(arrayData), .busy(busy), .rdData(rdData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int durOf(input int op);
    return (op == 0) ? PROG_CYC : (op == 1) ? SECT_CYC : CHIP_CYC;
  endfunction

  // Called at a negedge; returns at the negedge after the sampling edge.
  task automatic startOp(input int op, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input logic [2:0] g);
    startReq = 1'b1; opType = op[1:0]; progAddr = a; progData = d;
    {ceN, oeN, weN} = g;
    @(negedge clk);
    startReq = 1'b0; {ceN, oeN, weN} = 3'b111;
  endtask

  task automatic countBusy(output int n);
    n = 0;
    while (busy && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Polls through a whole operation: R4 R5 R6 R7, then R8 after completion.
  task automatic pollRun(input int op, input logic [DATA_W-1:0] d, input int lateStart);
    logic [ADDR_W-1:0] a;
    logic exp7;
    logic tog;
    logic [DATA_W-1:0] expV;
    logic [DATA_W-1:0] prev;
    a = 18'h1234;
    tog = 1'b0;
    startOp(op, a, d, 3'b010);
    for (int i = 0; i < durOf(op); i++) begin
      rdAddr = (i % 2 == 0) ? a : a + 18'd7;
      arrayData = DATA_W'(i * 37 + 11);
      rdEn = (i >= lateStart) && (i % 3 != 1);
      #1;
      if (op == 0) exp7 = (rdAddr == a) ? ~d[7] : arrayData[7];
      else exp7 = 1'b0;
      expV = {exp7, tog, arrayData[5:0]};
      check(busy == 1'b1, "R2 busy during op", busy, 1);
      if (op == 0) check(rdData[7] == exp7, "R4 program poll bit7", rdData[7], exp7);
      else check(rdData[7] == exp7, "R5 erase poll bit7", rdData[7], exp7);
      check(rdData[6] == tog, "R6 toggle bit", rdData[6], tog);
      check(rdData[5:0] == expV[5:0], "R7 low bits", rdData[5:0], expV[5:0]);
      if (rdEn) tog = ~tog;
      @(negedge clk);
    end
    rdEn = 1'b1; rdAddr = a; arrayData = 8'hC3;
    #1;
    check(busy == 1'b0, "R2 busy ends", busy, 0);
    check(rdData == 8'hC3, "R8 true data after completion", rdData, 8'hC3);
    prev = rdData;
    @(negedge clk);
    #1;
    check(rdData == prev, "R8 bit6 stopped toggling", rdData, prev);
    rdEn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int n;
    bool_dummy: begin end
    #3;
    check(busy == 1'b0, "R9 reset state busy", busy, 0);
    check(rdData == 8'h5A, "R8 reset state pass-through", rdData, 8'h5A);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R2: sweep every opcode and strobe combination
    for (int op = 0; op < 4; op++) begin
      for (int g = 0; g < 8; g++) begin
        bit legal;
        legal = (op != 3) && (g == 3'b010);
        startOp(op, 18'h0040, 8'h00, g[2:0]);
        #1;
        check(busy == legal, "R1 start gating", busy, legal);
        if (legal) begin
          countBusy(n);
          check(n == durOf(op), "R2 duration", n, durOf(op));
        end else begin
          @(negedge clk);
        end
      end
    end

    // R3: restart while busy is ignored
    startOp(0, 18'h0100, 8'h80, 3'b010);
    @(negedge clk);
    startOp(2, 18'h0200, 8'h00, 3'b010);
    countBusy(n);
    check(n == PROG_CYC - 2, "R3 restart ignored", n, PROG_CYC - 2);

    // R4..R8: poll patterns per operation, bit7 of data both ways, late polling
    pollRun(0, 8'h80, 0);
    pollRun(0, 8'h3F, 2);
    pollRun(1, 8'hFF, 0);
    pollRun(2, 8'h00, 4);

    // R9: asynchronous abort, then a clean restart with toggle at 0
    startOp(2, 18'h0300, 8'h00, 3'b010);
    @(negedge clk);
    @(negedge clk);
    #1 rstN = 1'b0;
    #1;
    check(busy == 1'b0, "R9 abort clears busy", busy, 0);
    arrayData = 8'h77;
    #1;
    check(rdData == 8'h77, "R9 read mode after abort", rdData, 8'h77);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    pollRun(0, 8'h01, 0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule